// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the two-wire slave front end of a byte-addressed serial memory. It oversamples the open-drain clock and data lines on a fast system clock and finds start, repeated start and stop conditions. It compares the select byte with three strap pins and collects a 16-bit byte address sent high byte first. It then runs byte and multi-byte writes, current-address reads, random reads and sequential reads. Acknowledges and read data leave the block on one active-high pull-low enable, which an open-drain pad turns into a low on the bus.

Storage sits behind a plain byte port. The engine presents an address, write data and a one-cycle write strobe. The back end returns read data for the presented address in the same cycle. A busy input from the back end marks an internal program cycle. While it is high the engine refuses every select byte, so a master can poll until the write has finished. A write-protect pin is watched from the start through the second address byte. If it is seen high in that window, the data bytes are refused and nothing is written. Reads ignore the pin.

Top module: `i2c_mem_slave`

## Requirements
- R1: A select byte sent MSB first as type code 1010, then bits equal to chip_en_i[2], chip_en_i[1] and chip_en_i[0], then the direction bit (1 read, 0 write) is acknowledged by a low on the bus in the ninth clock.
- R2: SDA falling while SCL is high starts a new select byte from any state, including mid-transaction. SDA rising while SCL is high ends the transaction and keeps any address already loaded.
- R3: A select byte with a wrong type code or wrong chip-enable bits gets no acknowledge. Every byte after it is ignored until the next start, and no write reaches the back end.
- R4: After a write select, two address bytes (high byte first) are acknowledged and loaded into the address counter. Only its low ADDR_W bits are kept. Each data byte after them is acknowledged, written at the counter, and the counter then advances by one.
- R5: If wp_i is high at any sampled cycle from the start through the acknowledge of the second address byte, select and address are still acknowledged. Every data byte is then left unacknowledged and no write strobe is issued.
- R6: A read select with no address phase returns the byte at the address counter, and the counter advances by one.
- R7: A write select plus two address bytes, then a repeated start and a read select, returns the byte at the new address.
- R8: While the master acknowledges each read byte, bytes from consecutive addresses follow. After address 2^ADDR_W-1 the next byte comes from address 0.
- R9: A high (no acknowledge) in the ninth clock of a read byte releases the bus and returns the engine to standby. Further clocks without a start read as all ones.
- R10: While busy_i is high, no select byte is acknowledged. Once it is low, the same select is acknowledged.
- R11: Reads return correct data and acknowledge the select regardless of wp_i.
- R12: sda_pull_o is low after reset and in standby. It rises only while SCL is low, and read data bits are driven MSB first, with sda_pull_o = 1 for a data bit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired bus) |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| chip_en_i | input | 3 | Strap value matched against select bits 3..1 |
| wp_i | input | 1 | Write protect, high blocks data writes |
| busy_i | input | 1 | Back end is in an internal write cycle |
| mem_addr_o | output | ADDR_W | Byte address to the back end |
| mem_wdata_o | output | 8 | Write data to the back end |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_rdata_i | input | 8 | Read data for mem_addr_o, same cycle |

## Verification
The checkers assume that each SCL low phase lasts at least four system clocks, which gives the synchronizer and the output register time to settle. The stimulus therefore holds every bus phase for six clocks. They also assume that busy_i does not change while a select byte and its acknowledge slot are in flight. The bench changes busy only between transactions, with a stop in between. Data on SDA changes only while SCL is low, except for intended start and stop conditions, so the synchronizer never sees a false bus condition.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_RACK
  } ph_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_sr[LAST];
      sda_p  <= sda_sr[LAST];
    end
  end

  assign sda_o      = sda_sr[LAST];
  assign scl_rise_o = scl_sr[LAST] & ~scl_p;
  assign scl_fall_o = ~scl_sr[LAST] & scl_p;
  assign start_o    = scl_sr[LAST] & scl_p & sda_p & ~sda_sr[LAST];
  assign stop_o     = scl_sr[LAST] & scl_p & ~sda_p & sda_sr[LAST];
endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        chip_en_i,
  input  logic              wp_i,
  input  logic              busy_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              sda_pull_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output ph_e               st_o
);
  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;

  ph_e               st_q, nxt_q;
  logic [3:0]        cnt_q;
  logic [7:0]        rx_q, tx_q, ahi_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wp_q, pull_q, mack_q;
  logic              sel_ok, byte_end, ack_end;

  assign sel_ok   = (rx_q[7:4] == TYPE_CODE) && (rx_q[3:1] == chip_en_i) && !busy_i;
  assign byte_end = scl_fall_i && (cnt_q == BIT_LAST);
  assign ack_end  = scl_fall_i && (cnt_q == ACK_SLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      nxt_q  <= ST_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      ahi_q  <= '0;
      addr_q <= '0;
      wp_q   <= 1'b0;
      pull_q <= 1'b0;
      mack_q <= 1'b0;
    end else if (start_i) begin
      st_q   <= ST_SEL;
      cnt_q  <= '0;
      pull_q <= 1'b0;
      mack_q <= 1'b0;
      wp_q   <= wp_i;
    end else if (stop_i) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pull_q <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      // protect window spans select and both address bytes
      if (st_q == ST_SEL || st_q == ST_AHI || st_q == ST_ALO) wp_q <= wp_q | wp_i;
      unique case (st_q)
        ST_SEL, ST_AHI, ST_ALO, ST_WR: begin
          if (scl_rise_i && cnt_q < BIT_LAST) begin
            rx_q  <= {rx_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_end) begin
            cnt_q <= ACK_SLOT;
            unique case (st_q)
              ST_SEL: begin
                if (sel_ok) begin
                  pull_q <= 1'b1;
                  nxt_q  <= rx_q[0] ? ST_RD : ST_AHI;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                pull_q <= 1'b1;
                ahi_q  <= rx_q;
                nxt_q  <= ST_ALO;
              end
              ST_ALO: begin
                pull_q <= 1'b1;
                addr_q <= ADDR_W'({ahi_q, rx_q});
                nxt_q  <= ST_WR;
              end
              default: begin
                nxt_q <= ST_WR;
                if (!wp_q) begin
                  pull_q <= 1'b1;
                  addr_q <= addr_q + ADDR_W'(1);
                end
              end
            endcase
          end else if (ack_end) begin
            cnt_q  <= '0;
            st_q   <= nxt_q;
            pull_q <= 1'b0;
            if (nxt_q == ST_RD) begin
              tx_q   <= mem_rdata_i;
              pull_q <= ~mem_rdata_i[7];
              addr_q <= addr_q + ADDR_W'(1);
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (cnt_q == BIT_LAST) begin
              pull_q <= 1'b0;
              st_q   <= ST_RACK;
            end else begin
              tx_q   <= {tx_q[6:0], 1'b0};
              pull_q <= ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            if (sda_i) st_q <= ST_IDLE;
            else       mack_q <= 1'b1;
          end else if (scl_fall_i && mack_q) begin
            mack_q <= 1'b0;
            cnt_q  <= '0;
            st_q   <= ST_RD;
            tx_q   <= mem_rdata_i;
            pull_q <= ~mem_rdata_i[7];
            addr_q <= addr_q + ADDR_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign mem_we_o    = (st_q == ST_WR) && byte_end && !wp_q;
  assign mem_wdata_o = rx_q;
  assign mem_addr_o  = addr_q;
  assign sda_pull_o  = pull_q;
  assign st_o        = st_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [2:0]        chip_en_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  ph_e  fsm_st;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2c_mem_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_evt),
    .stop_i      (stop_evt),
    .chip_en_i   (chip_en_i),
    .wp_i        (wp_i),
    .busy_i      (busy_i),
    .mem_rdata_i (mem_rdata_i),
    .sda_pull_o  (sda_pull_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .st_o        (fsm_st)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_pull_o,
  input logic mem_we_o,
  input logic busy_i,
  input ph_e  st_i,
  input logic start_i
);
  // R12
  pull_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_i);

  // R9
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_IDLE) |-> !sda_pull_o);

  // R10
  busy_no_sel_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SEL && busy_i) |-> !sda_pull_o);

  // R2
  start_to_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_i == ST_SEL));

  // R4
  we_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R5
  we_only_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (st_i == ST_WR));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_pull_o (sda_pull_o),
  .mem_we_o   (mem_we_o),
  .busy_i     (busy_i),
  .st_i       (fsm_st),
  .start_i    (start_evt)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int AW = 8;
  localparam int Q  = 6;
  localparam logic [2:0] CE = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, CE, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, CE, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wp = 1'b0, busy = 1'b0;
  logic sda_pull, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [1<<AW];
  logic sda_bus;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign sda_bus   = m_sda & ~sda_pull;
  assign mem_rdata = mem[mem_addr];

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= pat(8'(i));
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  i2c_mem_slave #(.ADDR_W(AW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .sda_pull_o  (sda_pull),
    .chip_en_i   (CE),
    .wp_i        (wp),
    .busy_i      (busy),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bstop();
    m_sda = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b1; hold();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold();
      m_scl = 1'b1; hold(); hold();
      m_scl = 1'b0; hold();
    end
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    ack = ~sda_bus; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold();
      m_scl = 1'b1; hold();
      d[i] = sda_bus; hold();
      m_scl = 1'b0;
    end
    m_sda = ~mack; hold();
    m_scl = 1'b1; hold(); hold();
    m_scl = 1'b0; hold();
    m_sda = 1'b1;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    bstart();
    wbyte(SEL_W, a); chk({req, " select ack"}, 8'(a), 8'd1);
    wbyte(hi, a);    chk({req, " addr hi ack"}, 8'(a), 8'd1);
    wbyte(lo, a);    chk({req, " addr lo ack"}, 8'(a), 8'd1);
  endtask

  task automatic t_reset();
    chk("R12 pull low after reset", 8'(sda_pull), 8'd0);
    chk("R12 no write after reset", 8'(mem_we), 8'd0);
  endtask

  task automatic t_write();
    logic a;
    set_addr(8'h7F, 8'h10, "R1 R4");
    wbyte(8'hA1, a); chk("R4 data0 ack", 8'(a), 8'd1);
    wbyte(8'hA2, a); chk("R4 data1 ack", 8'(a), 8'd1);
    wbyte(8'hA3, a); chk("R4 data2 ack", 8'(a), 8'd1);
    bstop(); hold();
    chk("R4 mem 10", mem[8'h10], 8'hA1);
    chk("R4 mem 11", mem[8'h11], 8'hA2);
    chk("R4 mem 12", mem[8'h12], 8'hA3);
  endtask

  task automatic t_cur_read();
    logic a; logic [7:0] d;
    bstart(); wbyte(SEL_R, a); chk("R6 read select ack", 8'(a), 8'd1);
    rbyte(1'b0, d); bstop();
    chk("R6 R12 current read", d, pat(8'h13));
    bstart(); wbyte(SEL_R, a);
    rbyte(1'b0, d); bstop();
    chk("R6 counter advanced", d, pat(8'h14));
  endtask

  task automatic t_rand_read();
    logic a; logic [7:0] d;
    set_addr(8'h00, 8'h11, "R7");
    bstart(); wbyte(SEL_R, a); chk("R2 R7 repeated start select", 8'(a), 8'd1);
    rbyte(1'b0, d); bstop();
    chk("R7 random read", d, 8'hA2);
  endtask

  task automatic t_seq_wrap();
    logic a; logic [7:0] d;
    set_addr(8'h00, 8'hFE, "R8");
    bstart(); wbyte(SEL_R, a);
    rbyte(1'b1, d); chk("R8 seq FE", d, pat(8'hFE));
    rbyte(1'b1, d); chk("R8 seq FF", d, pat(8'hFF));
    rbyte(1'b1, d); chk("R8 wrap 00", d, pat(8'h00));
    rbyte(1'b0, d); chk("R8 seq 01", d, pat(8'h01));
    bstop();
  endtask

  task automatic t_wp_write();
    logic a;
    bstart();
    wbyte(SEL_W, a); chk("R5 select ack", 8'(a), 8'd1);
    wp = 1'b1;
    wbyte(8'h00, a); chk("R5 addr hi ack", 8'(a), 8'd1);
    wp = 1'b0;
    wbyte(8'h20, a); chk("R5 addr lo ack", 8'(a), 8'd1);
    wbyte(8'h33, a); chk("R5 data nack", 8'(a), 8'd0);
    wbyte(8'h44, a); chk("R5 data2 nack", 8'(a), 8'd0);
    bstop(); hold();
    chk("R5 mem 20 kept", mem[8'h20], pat(8'h20));
    chk("R5 mem 21 kept", mem[8'h21], pat(8'h21));
  endtask

  task automatic t_wp_read();
    logic a; logic [7:0] d;
    wp = 1'b1;
    set_addr(8'h00, 8'h10, "R11");
    bstart(); wbyte(SEL_R, a); chk("R11 read select ack", 8'(a), 8'd1);
    rbyte(1'b0, d); bstop();
    chk("R11 read under wp", d, 8'hA1);
    wp = 1'b0;
  endtask

  task automatic t_mismatch();
    logic a;
    bstart();
    wbyte({4'b1010, 3'b100, 1'b0}, a); chk("R3 wrong ce nack", 8'(a), 8'd0);
    wbyte(8'h00, a); chk("R3 addr ignored", 8'(a), 8'd0);
    wbyte(8'h30, a); chk("R3 addr2 ignored", 8'(a), 8'd0);
    wbyte(8'h99, a); chk("R3 data ignored", 8'(a), 8'd0);
    bstop(); hold();
    chk("R3 mem 30 kept", mem[8'h30], pat(8'h30));
    bstart();
    wbyte({4'b0010, CE, 1'b0}, a); chk("R3 wrong type nack", 8'(a), 8'd0);
    bstop();
  endtask

  task automatic t_busy();
    logic a; logic [7:0] d;
    busy = 1'b1;
    bstart(); wbyte(SEL_R, a); chk("R10 busy nack", 8'(a), 8'd0);
    bstop();
    busy = 1'b0; hold();
    bstart(); wbyte(SEL_R, a); chk("R10 ack after busy", 8'(a), 8'd1);
    rbyte(1'b0, d); bstop();
  endtask

  task automatic t_noack();
    logic a; logic [7:0] d;
    set_addr(8'h00, 8'h00, "R9");
    bstart(); wbyte(SEL_R, a);
    rbyte(1'b0, d);
    chk("R9 released after nack", 8'(sda_pull), 8'd0);
    rbyte(1'b0, d);
    chk("R9 standby reads ones", d, 8'hFF);
    bstop();
  endtask

  task automatic t_stop_mid();
    logic a; logic [7:0] d;
    set_addr(8'h00, 8'h40, "R2");
    bstop(); hold();
    chk("R2 stop no write", mem[8'h40], pat(8'h40));
    bstart(); wbyte(SEL_R, a);
    rbyte(1'b0, d); bstop();
    chk("R2 address kept over stop", d, pat(8'h40));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_cur_read();
    t_rand_read();
    t_seq_wrap();
    t_wp_write();
    t_wp_read();
    t_mismatch();
    t_busy();
    t_noack();
    t_stop_mid();
    hold();
    chk("R12 idle at end", 8'(sda_pull), 8'd0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=done");
      summary();
      $finish;
    end
  end
endmodule